// File: doc/BRIEF.md
# Unified Data-Space Access Decoder

This block sits between the load/store stage of an 8-bit microcontroller core and the storage behind it. Every byte access in the core's single flat data address space is steered to one of four places: the general register file, a small group of special CPU registers that the block keeps itself, the external peripheral bus, or data RAM. A second request port carries the I/O instructions, which name an I/O port number directly rather than a data address. It reaches the same I/O window as the data-space path.

The special registers are the block's own state. They are four pointer-extension bytes (for the D, X, Y and Z pointers), an indirect-jump extension byte, a 16-bit stack pointer that is written one byte at a time, and the status byte. The extension bytes are exposed to the core already shifted into bits 23:16 of a 24-bit value. The register file, the RAM and the peripherals are outside the block. Each is reached through a request strobe with its address and write data, and each returns read data one cycle later. Read results reach the core with a valid strobe one cycle after the request.

Top module: `dspace_decoder`

## Requirements
- R1: A data address below 32 drives `rf_req` with `rf_idx` equal to the address. A read returns `rf_rdata`.
- R2: A data address from 32 to 95 whose port number (address − 32) is below 0x38 drives `xio_req` with `xio_port` equal to that port number. A read returns `xio_rdata`.
- R3: A data address of 96 or above drives `ram_req` with `ram_addr` equal to the full address. A read returns `ram_rdata`.
- R4: Ports 0x38, 0x39, 0x3A and 0x3B hold the D, X, Y and Z extension bytes. `seg_en` bits 0, 1, 2 and 3 enable them in that order. A write stores the byte only while its enable bit is 1 and is otherwise ignored. A read returns the stored byte. The byte appears on bits 23:16 of its 24-bit output, with bits 15:0 at zero.
- R5: Port 0x3C holds the indirect extension byte. Every write stores it, whatever the enables. It appears on bits 23:16 of `seg_ind_o`.
- R6: A write to port 0x3D replaces stack pointer bits 7:0 and keeps bits 15:8. A read returns bits 7:0.
- R7: A write to port 0x3E replaces stack pointer bits 15:8 only while `sp_wide_en` is 1, and is otherwise ignored. A read returns bits 15:8.
- R8: Port 0x3F reads and writes the 8-bit status register, which is visible on `status_o`.
- R9: An `io_req` on port p acts exactly like a data access at address p + 32. When `io_req` and `ds_req` are both high, the port request is served and the data request is dropped.
- R10: A read asserts `rvalid` for one cycle, one cycle after the request, and a write never asserts it. At most one external request strobe is high at a time. An access to a special register raises no external strobe.
- R11: Synchronous active-high reset clears every special register and `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_en | input | 4 | Write enables for the D, X, Y, Z extension bytes (bit 0 = D) |
| sp_wide_en | input | 1 | Enables writes to the stack pointer high byte |
| ds_req | input | 1 | Data-space access request |
| ds_we | input | 1 | Data-space write (1) or read (0) |
| ds_addr | input | AW | Data-space byte address |
| ds_wdata | input | 8 | Data-space write byte |
| io_req | input | 1 | Port-addressed access request |
| io_we | input | 1 | Port access write (1) or read (0) |
| io_port | input | IOW | I/O port number |
| io_wdata | input | 8 | Port access write byte |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 8 | Read data |
| rf_req | output | 1 | Register file request |
| rf_we | output | 1 | Register file write |
| rf_idx | output | 5 | Register index |
| rf_wdata | output | 8 | Register write byte |
| rf_rdata | input | 8 | Register read byte, one cycle after the request |
| xio_req | output | 1 | External I/O request |
| xio_we | output | 1 | External I/O write |
| xio_port | output | IOW | External I/O port number |
| xio_wdata | output | 8 | External I/O write byte |
| xio_rdata | input | 8 | External I/O read byte, one cycle after the request |
| ram_req | output | 1 | Data RAM request |
| ram_we | output | 1 | Data RAM write |
| ram_addr | output | AW | Data RAM byte address |
| ram_wdata | output | 8 | Data RAM write byte |
| ram_rdata | input | 8 | Data RAM read byte, one cycle after the request |
| seg_d_o | output | 24 | D extension byte in bits 23:16 |
| seg_x_o | output | 24 | X extension byte in bits 23:16 |
| seg_y_o | output | 24 | Y extension byte in bits 23:16 |
| seg_z_o | output | 24 | Z extension byte in bits 23:16 |
| seg_ind_o | output | 24 | Indirect extension byte in bits 23:16 |
| stack_ptr_o | output | 16 | Stack pointer |
| status_o | output | 8 | Status register |

## Verification
The hardest case to reach is a write that is ignored. A gated extension byte or stack-pointer high byte has to hold a known nonzero value before the write, or the ignored write cannot be told apart from one that stored a zero. The stimulus therefore first loads every special register with distinct values while all enables are high. It then clears the enables and writes again, and checks the exposed 24-bit and 16-bit outputs. A further case drives both request ports in the same cycle, aimed at a special register and at RAM. The read result shows which request won, and a count of RAM strobes shows that the other request was dropped.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

  typedef enum logic [1:0] {
    TGT_RF   = 2'd0,
    TGT_XIO  = 2'd1,
    TGT_RAM  = 2'd2,
    TGT_SPEC = 2'd3
  } tgt_e;

  // Special register slot: low three bits of the port inside the top 8 ports
  typedef enum logic [2:0] {
    SPR_SEG_D  = 3'd0,
    SPR_SEG_X  = 3'd1,
    SPR_SEG_Y  = 3'd2,
    SPR_SEG_Z  = 3'd3,
    SPR_IND    = 3'd4,
    SPR_SP_LO  = 3'd5,
    SPR_SP_HI  = 3'd6,
    SPR_STATUS = 3'd7
  } spr_e;

  localparam int NUM_SEG = 4;

endpackage

// File: rtl/dspace_addr_decode.sv
module dspace_addr_decode
  import dspace_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 32,
  parameter int NIO  = 64,
  localparam int IOW = $clog2(NIO)
) (
  input  logic [AW-1:0]  addr,
  output tgt_e           tgt,
  output logic [IOW-1:0] io_off,
  output spr_e           spr
);
  localparam logic [AW-1:0]  IO_LO   = AW'(NREG);
  localparam logic [AW-1:0]  RAM_LO  = AW'(NREG + NIO);
  localparam logic [IOW-1:0] SPEC_LO = IOW'(NIO - 8);

  always_comb begin
    io_off = addr[IOW-1:0] - IOW'(NREG);
    spr    = spr_e'(io_off[2:0]);
    if (addr < IO_LO)        tgt = TGT_RF;
    else if (addr < RAM_LO)  tgt = (io_off >= SPEC_LO) ? TGT_SPEC : TGT_XIO;
    else                     tgt = TGT_RAM;
  end
endmodule

// File: rtl/dspace_spec_regs.sv
module dspace_spec_regs
  import dspace_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  spr_e                spr,
  input  logic [7:0]          wdata,
  input  logic [NUM_SEG-1:0]  seg_en,
  input  logic                sp_wide_en,
  output logic [NUM_SEG-1:0][7:0] seg_q,
  output logic [7:0]          ind_q,
  output logic [15:0]         sp_q,
  output logic [7:0]          status_q,
  output logic [7:0]          rd_byte
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        seg_q[i] <= '0;
      else if (wr && spr == spr_e'(i) && seg_en[i])
        seg_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q    <= '0;
      sp_q     <= '0;
      status_q <= '0;
    end else if (wr) begin
      case (spr)
        SPR_IND:    ind_q       <= wdata;
        SPR_SP_LO:  sp_q[7:0]   <= wdata;
        SPR_SP_HI:  if (sp_wide_en) sp_q[15:8] <= wdata;
        SPR_STATUS: status_q    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (spr)
      SPR_SEG_D:  rd_byte = seg_q[0];
      SPR_SEG_X:  rd_byte = seg_q[1];
      SPR_SEG_Y:  rd_byte = seg_q[2];
      SPR_SEG_Z:  rd_byte = seg_q[3];
      SPR_IND:    rd_byte = ind_q;
      SPR_SP_LO:  rd_byte = sp_q[7:0];
      SPR_SP_HI:  rd_byte = sp_q[15:8];
      default:    rd_byte = status_q;
    endcase
  end
endmodule

// File: rtl/dspace_rdata_mux.sv
module dspace_rdata_mux
  import dspace_pkg::*;
(
  input  tgt_e       sel,
  input  logic [7:0] rf_rdata,
  input  logic [7:0] xio_rdata,
  input  logic [7:0] ram_rdata,
  input  logic [7:0] spec_rdata,
  output logic [7:0] rdata
);
  always_comb begin
    unique case (sel)
      TGT_RF:  rdata = rf_rdata;
      TGT_XIO: rdata = xio_rdata;
      TGT_RAM: rdata = ram_rdata;
      default: rdata = spec_rdata;
    endcase
  end
endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dspace_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 32,
  parameter int NIO  = 64,
  localparam int IOW = $clog2(NIO),
  localparam int RW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     seg_en,
  input  logic           sp_wide_en,
  input  logic           ds_req,
  input  logic           ds_we,
  input  logic [AW-1:0]  ds_addr,
  input  logic [7:0]     ds_wdata,
  input  logic           io_req,
  input  logic           io_we,
  input  logic [IOW-1:0] io_port,
  input  logic [7:0]     io_wdata,
  output logic           rvalid,
  output logic [7:0]     rdata,
  output logic           rf_req,
  output logic           rf_we,
  output logic [RW-1:0]  rf_idx,
  output logic [7:0]     rf_wdata,
  input  logic [7:0]     rf_rdata,
  output logic           xio_req,
  output logic           xio_we,
  output logic [IOW-1:0] xio_port,
  output logic [7:0]     xio_wdata,
  input  logic [7:0]     xio_rdata,
  output logic           ram_req,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [7:0]     ram_wdata,
  input  logic [7:0]     ram_rdata,
  output logic [23:0]    seg_d_o,
  output logic [23:0]    seg_x_o,
  output logic [23:0]    seg_y_o,
  output logic [23:0]    seg_z_o,
  output logic [23:0]    seg_ind_o,
  output logic [15:0]    stack_ptr_o,
  output logic [7:0]     status_o
);
  // Request merge: the port path wins and is mapped into the data space
  logic          acc_req, acc_we;
  logic [AW-1:0] acc_addr;
  logic [7:0]    acc_wdata;

  always_comb begin
    acc_req   = io_req | ds_req;
    acc_we    = io_req ? io_we : ds_we;
    acc_addr  = io_req ? (AW'(io_port) + AW'(NREG)) : ds_addr;
    acc_wdata = io_req ? io_wdata : ds_wdata;
  end

  tgt_e           tgt;
  logic [IOW-1:0] io_off;
  spr_e           spr;

  dspace_addr_decode #(.AW(AW), .NREG(NREG), .NIO(NIO)) u_dec (
    .addr   (acc_addr),
    .tgt    (tgt),
    .io_off (io_off),
    .spr    (spr)
  );

  logic [NUM_SEG-1:0][7:0] seg_q;
  logic [7:0]  ind_q, status_q, spec_rd;
  logic [15:0] sp_q;

  dspace_spec_regs u_spr (
    .clk        (clk),
    .rst        (rst),
    .wr         (acc_req && acc_we && tgt == TGT_SPEC),
    .spr        (spr),
    .wdata      (acc_wdata),
    .seg_en     (seg_en),
    .sp_wide_en (sp_wide_en),
    .seg_q      (seg_q),
    .ind_q      (ind_q),
    .sp_q       (sp_q),
    .status_q   (status_q),
    .rd_byte    (spec_rd)
  );

  // Outgoing requests
  always_comb begin
    rf_req    = acc_req && tgt == TGT_RF;
    rf_we     = acc_we;
    rf_idx    = acc_addr[RW-1:0];
    rf_wdata  = acc_wdata;
    xio_req   = acc_req && tgt == TGT_XIO;
    xio_we    = acc_we;
    xio_port  = io_off;
    xio_wdata = acc_wdata;
    ram_req   = acc_req && tgt == TGT_RAM;
    ram_we    = acc_we;
    ram_addr  = acc_addr;
    ram_wdata = acc_wdata;
  end

  // Response stage: registered decode and special-register read byte
  tgt_e       rsel_q;
  logic [7:0] spec_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      rsel_q    <= TGT_RF;
      spec_rd_q <= '0;
    end else begin
      rvalid <= acc_req && !acc_we;
      if (acc_req && !acc_we) begin
        rsel_q    <= tgt;
        spec_rd_q <= spec_rd;
      end
    end
  end

  dspace_rdata_mux u_mux (
    .sel        (rsel_q),
    .rf_rdata   (rf_rdata),
    .xio_rdata  (xio_rdata),
    .ram_rdata  (ram_rdata),
    .spec_rdata (spec_rd_q),
    .rdata      (rdata)
  );

  assign seg_d_o     = {seg_q[0], 16'h0000};
  assign seg_x_o     = {seg_q[1], 16'h0000};
  assign seg_y_o     = {seg_q[2], 16'h0000};
  assign seg_z_o     = {seg_q[3], 16'h0000};
  assign seg_ind_o   = {ind_q, 16'h0000};
  assign stack_ptr_o = sp_q;
  assign status_o    = status_q;
endmodule

// File: rtl/dspace_decoder_chk.sv
module dspace_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  seg_en,
  input logic        sp_wide_en,
  input logic        ds_req,
  input logic        ds_we,
  input logic        io_req,
  input logic        io_we,
  input logic        rvalid,
  input logic        rf_req,
  input logic        xio_req,
  input logic        ram_req,
  input logic [23:0] seg_d_o,
  input logic [15:0] stack_ptr_o,
  input logic [7:0]  status_o
);
  logic any_req, any_we;
  assign any_req = ds_req | io_req;
  assign any_we  = io_req ? io_we : ds_we;

  a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
    (any_req && !any_we) |=> rvalid);

  a_r10_write_silent: assert property (@(posedge clk) disable iff (rst)
    (!any_req || any_we) |=> !rvalid);

  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_req, xio_req, ram_req}));

  a_r4_seg_d_gated: assert property (@(posedge clk) disable iff (rst)
    !seg_en[0] |=> $stable(seg_d_o));

  a_r7_sp_hi_gated: assert property (@(posedge clk) disable iff (rst)
    !sp_wide_en |=> $stable(stack_ptr_o[15:8]));

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (stack_ptr_o == 16'h0 && status_o == 8'h0 && seg_d_o == 24'h0 && !rvalid));
endmodule

bind dspace_decoder dspace_decoder_chk u_chk (.*);

// File: tb/dspace_decoder_tb.sv
module dspace_decoder_tb;
  localparam int AW = 16;
  localparam int IOW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0] seg_en = 4'hF;
  logic sp_wide_en = 1'b1;
  logic ds_req = 0, ds_we = 0, io_req = 0, io_we = 0;
  logic [AW-1:0] ds_addr = '0;
  logic [7:0] ds_wdata = '0, io_wdata = '0;
  logic [IOW-1:0] io_port = '0;
  logic rvalid; logic [7:0] rdata;
  logic rf_req, rf_we; logic [4:0] rf_idx; logic [7:0] rf_wdata; logic [7:0] rf_rdata = '0;
  logic xio_req, xio_we; logic [IOW-1:0] xio_port; logic [7:0] xio_wdata; logic [7:0] xio_rdata = '0;
  logic ram_req, ram_we; logic [AW-1:0] ram_addr; logic [7:0] ram_wdata; logic [7:0] ram_rdata = '0;
  logic [23:0] seg_d_o, seg_x_o, seg_y_o, seg_z_o, seg_ind_o;
  logic [15:0] stack_ptr_o; logic [7:0] status_o;

  dspace_decoder u_dut (.*);

  // External models: fixed read functions, last-write capture, strobe counts
  int ext_cnt = 0, ram_cnt = 0;
  logic [4:0] rf_last_idx = '0;  logic [7:0] rf_last_wd = '0;
  logic [IOW-1:0] xio_last_port = '0; logic [7:0] xio_last_wd = '0;
  logic [AW-1:0] ram_last_addr = '0; logic [7:0] ram_last_wd = '0;

  always @(posedge clk) begin
    rf_rdata  <= {3'b101, rf_idx};
    xio_rdata <= {2'b00, xio_port} ^ 8'hA5;
    ram_rdata <= ram_addr[7:0] + ram_addr[15:8];
    if (rf_req || xio_req || ram_req) ext_cnt <= ext_cnt + 1;
    if (ram_req) ram_cnt <= ram_cnt + 1;
    if (rf_req && rf_we) begin rf_last_idx <= rf_idx; rf_last_wd <= rf_wdata; end
    if (xio_req && xio_we) begin xio_last_port <= xio_port; xio_last_wd <= xio_wdata; end
    if (ram_req && ram_we) begin ram_last_addr <= ram_addr; ram_last_wd <= ram_wdata; end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access; returns rdata and rvalid sampled in the response cycle
  task automatic access(input bit use_port, input bit we, input logic [15:0] addr,
                        input logic [7:0] wd, output logic [7:0] rd, output logic rv);
    @(negedge clk);
    if (use_port) begin io_req = 1; io_we = we; io_port = addr[IOW-1:0]; io_wdata = wd; end
    else begin ds_req = 1; ds_we = we; ds_addr = addr; ds_wdata = wd; end
    @(negedge clk);
    rd = rdata; rv = rvalid;
    io_req = 0; ds_req = 0; io_we = 0; ds_we = 0;
  endtask

  // {port, we, addr[15:0], wdata, expected read}
  localparam int NV = 24;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b1,16'h005D,8'h34,8'h00}, {1'b0,1'b1,16'h005E,8'h12,8'h00},
    {1'b0,1'b0,16'h005D,8'h00,8'h34}, {1'b1,1'b0,16'h003E,8'h00,8'h12},
    {1'b1,1'b1,16'h003F,8'h81,8'h00}, {1'b0,1'b0,16'h005F,8'h00,8'h81},
    {1'b1,1'b1,16'h0038,8'hAA,8'h00}, {1'b0,1'b0,16'h0058,8'h00,8'hAA},
    {1'b0,1'b1,16'h0059,8'h11,8'h00}, {1'b1,1'b0,16'h0039,8'h00,8'h11},
    {1'b0,1'b1,16'h005A,8'h22,8'h00}, {1'b1,1'b0,16'h003A,8'h00,8'h22},
    {1'b1,1'b1,16'h003B,8'h33,8'h00}, {1'b0,1'b0,16'h005B,8'h00,8'h33},
    {1'b0,1'b1,16'h005C,8'h44,8'h00}, {1'b1,1'b0,16'h003C,8'h00,8'h44},
    {1'b0,1'b0,16'h0005,8'h00,8'hA5}, {1'b0,1'b0,16'h001F,8'h00,8'hBF},
    {1'b0,1'b0,16'h0020,8'h00,8'hA5}, {1'b1,1'b0,16'h0010,8'h00,8'hB5},
    {1'b0,1'b0,16'h0057,8'h00,8'h92}, {1'b0,1'b0,16'h0060,8'h00,8'h60},
    {1'b0,1'b0,16'h1234,8'h00,8'h46}, {1'b0,1'b0,16'hFFFF,8'h00,8'hFE}
  };

  function automatic string tag_of(input bit p, input logic [15:0] a);
    logic [15:0] da = p ? (a & 16'h003F) + 16'd32 : a;
    if (da < 16'd32) return "R1 register file";
    if (da >= 16'd96) return "R3 data RAM";
    if (da < 16'h58) return "R2 external I/O";
    if (da < 16'h5C) return "R4 extension byte";
    if (da == 16'h5C) return "R5 indirect byte";
    if (da == 16'h5D) return "R6 stack low";
    if (da == 16'h5E) return "R7 stack high";
    return "R8 status";
  endfunction

  initial begin
    logic [7:0] rd; logic rv; int base;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 stack pointer reset", stack_ptr_o, 0);
    check("R11 status reset", status_o, 0);
    check("R11 seg D reset", seg_d_o, 0);
    check("R11 rvalid reset", rvalid, 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:8], rd, rv);
      if (!VEC[i][32]) begin
        check({tag_of(VEC[i][33], VEC[i][31:16]), " read data"}, rd, VEC[i][7:0]);
        check("R10 rvalid on read", rv, 1);
        if (VEC[i][33]) check("R9 port path", rd, VEC[i][7:0]);
      end else begin
        check("R10 no rvalid on write", rv, 0);
      end
    end

    check("R4 seg D in bits 23:16", seg_d_o, 24'hAA0000);
    check("R4 seg X", seg_x_o, 24'h110000);
    check("R4 seg Y", seg_y_o, 24'h220000);
    check("R4 seg Z", seg_z_o, 24'h330000);
    check("R5 indirect byte", seg_ind_o, 24'h440000);
    check("R6 stack pointer", stack_ptr_o, 16'h1234);
    check("R8 status", status_o, 8'h81);

    // Gated writes with features off
    seg_en = 4'h0; sp_wide_en = 0;
    access(0, 1, 16'h0058, 8'h55, rd, rv);
    check("R4 gated D write ignored", seg_d_o, 24'hAA0000);
    access(1, 1, 16'h003B, 8'h5A, rd, rv);
    check("R4 gated Z write ignored", seg_z_o, 24'h330000);
    access(0, 1, 16'h005E, 8'h99, rd, rv);
    check("R7 gated high write ignored", stack_ptr_o, 16'h1234);
    access(0, 1, 16'h005C, 8'h66, rd, rv);
    check("R5 indirect always writable", seg_ind_o, 24'h660000);
    access(0, 1, 16'h005D, 8'h78, rd, rv);
    check("R6 low write keeps high", stack_ptr_o, 16'h1278);
    seg_en = 4'b0100;
    access(0, 1, 16'h005A, 8'h7E, rd, rv);
    check("R4 only Y enabled", seg_y_o, 24'h7E0000);
    sp_wide_en = 1;
    access(1, 1, 16'h003E, 8'h9A, rd, rv);
    check("R7 enabled high write", stack_ptr_o, 16'h9A78);

    // External writes
    access(0, 1, 16'h0025, 8'h77, rd, rv);
    check("R2 write port", xio_last_port, 5);
    check("R2 write data", xio_last_wd, 8'h77);
    access(0, 1, 16'h0003, 8'h3C, rd, rv);
    check("R1 write index", rf_last_idx, 3);
    check("R1 write data", rf_last_wd, 8'h3C);
    access(0, 1, 16'h0080, 8'hC1, rd, rv);
    check("R3 write address", ram_last_addr, 16'h0080);
    check("R3 write data", ram_last_wd, 8'hC1);

    // Special access raises no external strobe
    base = ext_cnt;
    access(0, 1, 16'h005F, 8'h02, rd, rv);
    access(1, 0, 16'h003D, 8'h00, rd, rv);
    check("R10 special raises no strobe", ext_cnt - base, 0);
    check("R8 status write", status_o, 8'h02);

    // Both requests at once: port path wins
    base = ram_cnt;
    @(negedge clk);
    ds_req = 1; ds_we = 0; ds_addr = 16'h0060;
    io_req = 1; io_we = 0; io_port = 6'h3D;
    @(negedge clk);
    rd = rdata; rv = rvalid;
    ds_req = 0; io_req = 0;
    check("R9 port wins data", rd, 8'h78);
    check("R9 data request dropped", ram_cnt - base, 0);
    check("R10 single rvalid", rv, 1);
    @(negedge clk);
    check("R10 rvalid one cycle", rvalid, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule